// File: doc/BRIEF.md
# Real-Time-Clock Register Write-Protection Unlock Sequencer

This block guards the control and calendar registers of a real-time-clock register file. It watches every write on a simple memory-mapped register bus. Only a fixed series of seven byte-wide keys, each written to its own offset and in a set order, lifts the protection. When the series completes, the block raises an unlock flag. That flag enables the time counter and opens the protected upper part of the register map to writes.

Any write that is not the next expected key sends the series back to its start. The same write can also count as a fresh first step. Once open, the block stays open until reset. Two outputs help the surrounding register file. A per-write accept signal tells it whether a write may land. A status word at a fixed read offset reports how far the series has progressed.

Top module: `rtc_wprot_unlock`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `unlock` is 0 and the step index is 0.
- R2: The step index advances by one only when the write is the expected one for the current step. The expected writes, in order, are: offset 0x04 with byte 0xC6, 0x08 with 0x9A, 0x0C with 0x59, 0x10 with 0xA3, 0x14 with 0x57, 0x18 with 0x67, and 0x1C with 0xD2. Idle cycles (`bus_we` low) leave the index unchanged.
- R3: `unlock` goes high on the clock edge that captures the seventh correct write. From then on the step index reads 7.
- R4: While locked, a write to the current step's offset with the wrong byte returns the step index to 0.
- R5: While locked, a write to any offset other than the current step's offset returns the step index to 0. The one exception is a write of 0xC6 to offset 0x04, which sets the index to 1.
- R6: Only bits 7:0 of `bus_wdata` are compared with the key bytes. Bits above 7 have no effect.
- R7: `wr_accept` is high only while `bus_we` is high. It is always high for offsets below 0x20. For offsets of 0x20 and above, it is high only while `unlock` is high.
- R8: When `bus_addr` equals 0x28, `stat_rdata` returns the step index, zero-extended, whether the block is locked or not. At every other address it returns 0.
- R9: Once `unlock` is high, no write changes `unlock` or the step index. This includes wrong keys and a repeat of the full series.
- R10: Asserting `rst_n` while unlocked relocks the block. A complete new series is then needed to unlock it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| unlock | output | 1 | High once the full key series has been seen |
| wr_accept | output | 1 | Current write may reach its register |
| stat_rdata | output | 32 | Step index when `bus_addr` is 0x28, else 0 |

## Verification
The bench interrupts the series at several depths, both with a wrong byte and with a wrong offset. A design that only checks the offset, or that holds its position on an error, would then unlock early. The bench also sends a first key partway through the series and sends it twice in a row. This exposes a design that drops the restart and needs an extra write to recover. Key bytes carry random upper data bits, which catches a comparison wider than eight bits. After unlock, the bench writes bad keys and protected offsets to catch a block that relocks or keeps rejecting writes. A reset mid-run then has to close the gate again.

// File: rtl/wpu_pkg.sv
package wpu_pkg;

   // Number of keys in the full unlock series
   localparam int KEY_MAX    = 7;
   // Offset of the first key register and the spacing between them
   localparam int KEY_BASE   = 'h04;
   localparam int KEY_STRIDE = 4;

   typedef logic [7:0] key_byte_t;

   // Byte offset expected at a given step
   function automatic int key_off(input int step);
      return KEY_BASE + step * KEY_STRIDE;
   endfunction

   // Byte value expected at a given step
   function automatic key_byte_t key_val(input int step);
      case (step)
         0:       return 8'hC6;
         1:       return 8'h9A;
         2:       return 8'h59;
         3:       return 8'hA3;
         4:       return 8'h57;
         5:       return 8'h67;
         default: return 8'hD2;
      endcase
   endfunction

endpackage

// File: rtl/wpu_key_match.sv
module wpu_key_match #(
   parameter int ADDR_W = 8,
   parameter int KEY_W  = 8,
   parameter int KEY_N  = 7
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [KEY_W-1:0]  key_byte,
   output logic [KEY_N-1:0]  hit_vec
);

   // One comparator per step: offset and byte must both agree
   for (genvar g = 0; g < KEY_N; g++) begin : g_step
      localparam logic [ADDR_W-1:0] OFF = ADDR_W'(wpu_pkg::key_off(g));
      localparam logic [KEY_W-1:0]  VAL = KEY_W'(wpu_pkg::key_val(g));
      assign hit_vec[g] = (addr == OFF) && (key_byte == VAL);
   end

endmodule

// File: rtl/wpu_step_ctr.sv
module wpu_step_ctr #(
   parameter int KEY_N   = 7,
   parameter int STEP_W  = 3,
   parameter bit RESTART = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [KEY_N-1:0]  hit_vec,
   output logic [STEP_W-1:0] step_q,
   output logic              done
);

   localparam logic [STEP_W-1:0] LAST = STEP_W'(KEY_N);

   logic              exp_hit;
   logic              first_hit;
   logic [STEP_W-1:0] step_d;

   // Select the comparator that belongs to the current step
   always_comb begin
      exp_hit = 1'b0;
      for (int i = 0; i < KEY_N; i++) begin
         if (step_q == STEP_W'(i)) exp_hit = hit_vec[i];
      end
   end

   // Variant: whether a stray first key counts as a fresh start
   if (RESTART) begin : g_restart
      assign first_hit = hit_vec[0];
   end else begin : g_norestart
      assign first_hit = 1'b0;
   end

   assign done = (step_q == LAST);

   always_comb begin
      step_d = step_q;
      if (we && !done) begin
         if (exp_hit)        step_d = step_q + STEP_W'(1);
         else if (first_hit) step_d = STEP_W'(1);
         else                step_d = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step_q <= '0;
      else        step_q <= step_d;
   end

endmodule

// File: rtl/wpu_bus_gate.sv
module wpu_bus_gate #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int STEP_W    = 3,
   parameter int PROT_BASE = 'h20,
   parameter int STAT_OFS  = 'h28
) (
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic              open,
   input  logic [STEP_W-1:0] step,
   output logic              accept,
   output logic [DATA_W-1:0] rdata
);

   localparam logic [ADDR_W-1:0] PROT_A = ADDR_W'(PROT_BASE);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

   logic in_prot;

   assign in_prot = (addr >= PROT_A);
   assign accept  = we && (!in_prot || open);
   assign rdata   = (addr == STAT_A) ? DATA_W'(step) : '0;

endmodule

// File: rtl/rtc_wprot_unlock.sv
module rtc_wprot_unlock #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int KEY_W     = 8,
   parameter int KEY_N     = 7,
   parameter int PROT_BASE = 'h20,
   parameter int STAT_OFS  = 'h28,
   parameter bit RESTART   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic              unlock,
   output logic              wr_accept,
   output logic [DATA_W-1:0] stat_rdata
);

   localparam int STEP_W = $clog2(KEY_N + 1);

   // Elaboration-time parameter checks
   if (KEY_N < 1 || KEY_N > wpu_pkg::KEY_MAX) begin : g_bad_keyn
      $error("KEY_N out of range");
   end
   if (KEY_W > DATA_W) begin : g_bad_keyw
      $error("KEY_W wider than DATA_W");
   end
   if (STAT_OFS >= (1 << ADDR_W) || PROT_BASE >= (1 << ADDR_W)) begin : g_bad_addr
      $error("offset does not fit ADDR_W");
   end
   if (wpu_pkg::key_off(KEY_N - 1) >= PROT_BASE) begin : g_bad_prot
      $error("key registers must lie below PROT_BASE");
   end
   if (STEP_W > DATA_W) begin : g_bad_stepw
      $error("status does not fit DATA_W");
   end

   logic [KEY_N-1:0]  hit_vec;
   logic [STEP_W-1:0] step_q;
   logic              done;

   wpu_key_match #(
      .ADDR_W (ADDR_W),
      .KEY_W  (KEY_W),
      .KEY_N  (KEY_N)
   ) u_match (
      .addr     (bus_addr),
      .key_byte (bus_wdata[KEY_W-1:0]),
      .hit_vec  (hit_vec)
   );

   wpu_step_ctr #(
      .KEY_N   (KEY_N),
      .STEP_W  (STEP_W),
      .RESTART (RESTART)
   ) u_step (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (bus_we),
      .hit_vec (hit_vec),
      .step_q  (step_q),
      .done    (done)
   );

   wpu_bus_gate #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .STEP_W    (STEP_W),
      .PROT_BASE (PROT_BASE),
      .STAT_OFS  (STAT_OFS)
   ) u_gate (
      .we     (bus_we),
      .addr   (bus_addr),
      .open   (done),
      .step   (step_q),
      .accept (wr_accept),
      .rdata  (stat_rdata)
   );

   assign unlock = done;

endmodule

// File: rtl/wpu_chk.sv
module wpu_chk #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int KEY_N     = 7,
   parameter int STEP_W    = 3,
   parameter int PROT_BASE = 'h20,
   parameter int STAT_OFS  = 'h28
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              unlock,
   input logic              wr_accept,
   input logic [DATA_W-1:0] stat_rdata,
   input logic [STEP_W-1:0] step_q
);

   // R1
   reset_lock_chk: assert property (@(posedge clk) !rst_n |=> !unlock);

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> $stable(step_q));

   // R2
   step_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(step_q) |-> (step_q == $past(step_q) + STEP_W'(1)) || (step_q <= STEP_W'(1)));

   // R3
   unlock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlock) |-> $past(bus_we));

   // R9
   unlock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unlock |=> unlock && $stable(step_q));

   // R7
   accept_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_accept |-> bus_we);

   // R7
   prot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !unlock && bus_addr >= ADDR_W'(PROT_BASE)) |-> !wr_accept);

   // R8
   stat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(STAT_OFS)) |-> (stat_rdata <= DATA_W'(KEY_N)));

endmodule

bind rtc_wprot_unlock wpu_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .KEY_N     (KEY_N),
   .STEP_W    (STEP_W),
   .PROT_BASE (PROT_BASE),
   .STAT_OFS  (STAT_OFS)
) u_wpu_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_we     (bus_we),
   .bus_addr   (bus_addr),
   .unlock     (unlock),
   .wr_accept  (wr_accept),
   .stat_rdata (stat_rdata),
   .step_q     (step_q)
);

// File: tb/test_rtc_wprot_unlock.sv
module test_rtc_wprot_unlock;

   localparam int CLK_PERIOD = 10;
   localparam int STAT_A     = 'h28;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = 8'(STAT_A);
   logic [31:0] bus_wdata = '0;
   logic        unlock;
   logic        wr_accept;
   logic [31:0] stat_rdata;

   int    n_checks = 0;
   int    n_fail   = 0;
   int    m_step   = 0;
   string cur_req  = "R1";

   int koff[7] = '{'h04, 'h08, 'h0C, 'h10, 'h14, 'h18, 'h1C};
   int kval[7] = '{'hC6, 'h9A, 'h59, 'hA3, 'h57, 'h67, 'hD2};

   always #(CLK_PERIOD / 2) clk = ~clk;

   rtc_wprot_unlock i_rtc_wprot_unlock (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .unlock     (unlock),
      .wr_accept  (wr_accept),
      .stat_rdata (stat_rdata)
   );

   // Behavioural reference for the step index
   function automatic int ref_next(int s, bit we, int a, int d);
      if (!we || s == 7) return s;
      if (a == koff[s] && (d & 'hFF) == kval[s]) return s + 1;
      if (a == 'h04 && (d & 'hFF) == 'hC6) return 1;
      return 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) m_step <= 0;
      else        m_step <= ref_next(m_step, bus_we, int'(bus_addr), int'(bus_wdata));
   end

   task automatic check(string tag, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
      end
   endtask

   // Compare every cycle, away from the active edge
   always @(negedge clk) begin
      int e_acc;
      int e_stat;
      e_acc  = (bus_we && (bus_addr < 8'h20 || m_step == 7)) ? 1 : 0;
      e_stat = (bus_addr == 8'(STAT_A)) ? m_step : 0;
      check(cur_req, "unlock", int'(unlock), (m_step == 7) ? 1 : 0);
      check("R7", "wr_accept", int'(wr_accept), e_acc);
      check("R8", "stat_rdata", int'(stat_rdata), e_stat);
   end

   task automatic wr(int a, int d);
      @(posedge clk); #1;
      bus_we = 1'b1; bus_addr = 8'(a); bus_wdata = 32'(d);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         bus_we = 1'b0; bus_addr = 8'(STAT_A); bus_wdata = '0;
      end
   endtask

   task automatic keys(int first, int count, int hi);
      for (int i = first; i < first + count; i++) wr(koff[i], (hi << 8) | kval[i]);
   endtask

   // Directed status check at the ports: read status during an idle cycle
   task automatic expect_step(string tag, int exp);
      idle(1);
      @(negedge clk);
      check(tag, "step", int'(stat_rdata), exp);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      cur_req = "R1";
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", "unlock in reset", int'(unlock), 0);
      rst_n = 1'b1;
      expect_step("R1", 0);

      // R2: partial progress, idle cycles keep position
      cur_req = "R2";
      keys(0, 3, 0);
      idle(3);
      expect_step("R2", 3);

      // R4: wrong byte at the right offset
      cur_req = "R4";
      wr('h10, 'h00);
      expect_step("R4", 0);
      keys(0, 5, 0);
      wr('h18, 'h66);
      expect_step("R4", 0);

      // R5: wrong offset, restart on first key, double first key
      cur_req = "R5";
      keys(0, 2, 0);
      wr('h14, 'h57);
      expect_step("R5", 0);
      keys(0, 3, 0);
      wr('h04, 'hC6);
      expect_step("R5", 1);
      wr('h04, 'hC6);
      wr('h04, 'hC6);
      expect_step("R5", 1);
      keys(1, 2, 0);
      wr('h2C, 'h00);
      expect_step("R5", 0);

      // R7: protected write while locked is refused and breaks the series
      cur_req = "R7";
      keys(0, 4, 0);
      wr('h20, 'h00);
      expect_step("R7", 0);

      // R6: upper data bits carry noise
      cur_req = "R6";
      wr('h04, 'hDEADBE00 | 'hC6);
      keys(1, 6, 'h5A5A5A);
      expect_step("R3", 7);
      check("R3", "unlock after series", int'(unlock), 1);

      // R9: stays open through junk and a repeated series
      cur_req = "R9";
      wr('h04, 'h00);
      wr('h1C, 'hD2);
      keys(0, 7, 0);
      wr('h20, 'h01);
      wr('h2C, 'h00);
      expect_step("R9", 7);

      // R10: reset relocks, full series needed again
      cur_req = "R10";
      @(posedge clk); #1;
      rst_n = 1'b0;
      @(negedge clk);
      check("R10", "unlock in reset", int'(unlock), 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      expect_step("R10", 0);
      keys(0, 6, 0);
      expect_step("R10", 6);
      keys(6, 1, 0);
      expect_step("R10", 7);

      idle(2);
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule